// File: doc/BRIEF.md
# Receive Ring Pointer Manager

This block keeps the bookkeeping for a circular receive buffer of 32768 bytes. Incoming packet bytes arrive as a stream of one-byte strobes. For each byte the block gives the buffer write address. The address starts at the committed write pointer and advances by one per stored byte, wrapping at the top of the ring. The stream ends each packet with either a good or a bad end marker. On a good end, the committed write pointer moves forward by the packet length rounded up to a four-byte multiple. On a bad end, staging falls back to the committed pointer, so the next packet overwrites the rejected bytes.

Software owns the other pointer, the boundary. It writes that pointer through a register port once it has drained a packet from the ring. The block compares the two pointers to report the free space and the empty and full flags. The ring is full once less than one maximum-size frame of room remains. A packet that would run into the boundary stops writing at once, is never committed, and is counted as a drop.

Top module: `rx_ring_ptr_mgr`

## Requirements
- R1: After reset the write pointer, the boundary and the drop count are 0, `ring_empty` is 1, `ring_full` is 0 and `free_bytes` is 32768.
- R2: For each accepted byte, `buf_wr_en` is 1 in that same cycle and `buf_wr_addr` equals (write pointer + bytes already accepted in this packet) modulo 32768.
- R3: A good end marker (`end_good`=1, `end_bad`=0) on a packet that did not overrun advances the write pointer, from the next cycle, by the accepted byte count rounded up to a multiple of 4, modulo 32768. A zero-length packet leaves the pointer unchanged.
- R4: A bad end marker leaves the write pointer unchanged. Both markers together count as a bad end. The next packet's first byte is written at the committed write pointer.
- R5: A write on the boundary port stores the written value with its two low bits cleared. The new value is visible from the next cycle.
- R6: `free_bytes` is (boundary − write pointer) modulo 32768, or 32768 when the two are equal. `ring_empty` is 1 exactly when the two pointers are equal.
- R7: `ring_full` is 1 exactly when `free_bytes` is below 1536.
- R8: A byte is accepted only when (bytes already accepted + 1 + 4) ≤ `free_bytes`. The first refused byte marks the packet as overrun, and no later byte of that packet is written. When an overrun packet ends, by either marker, the write pointer stays put and `drop_cnt` rises by 1.
- R9: A boundary write and a packet end in the same cycle both take effect.
- R10: A byte strobe in the same cycle as an end marker belongs to the ending packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | One packet byte is to be stored this cycle |
| end_good | input | 1 | Current packet ends and passed validation |
| end_bad | input | 1 | Current packet ends and is rejected |
| bnd_wr_en | input | 1 | Software write strobe for the boundary pointer |
| bnd_wr_data | input | 15 | Boundary value to write |
| buf_wr_en | output | 1 | Store the current byte in the buffer |
| buf_wr_addr | output | 15 | Buffer byte address for the current byte |
| cur_ptr | output | 15 | Committed write pointer |
| bnd_ptr | output | 15 | Boundary pointer, four-byte aligned |
| free_bytes | output | 16 | Bytes between write pointer and boundary |
| ring_empty | output | 1 | Pointers are equal |
| ring_full | output | 1 | Less than one maximum frame of room |
| drop_cnt | output | 8 | Count of overrun packets, saturating |

## Verification
A packet's end and a boundary write by software can land in the same cycle. The first moves the write pointer and the second moves the boundary. The bench provokes this by raising the boundary strobe on the very cycle that carries the last byte and the good end marker. It then checks that both pointers, the free space and the empty flag all show the two updates together, with neither update lost.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  // round a byte count up to a multiple of 2**lg2
  function automatic int unsigned align_up(input int unsigned len, input int unsigned lg2);
    int unsigned unit;
    unit = 32'd1 << lg2;
    return ((len + unit - 32'd1) >> lg2) << lg2;
  endfunction

  // bytes between write pointer and boundary on a ring of 2**aw bytes
  function automatic int unsigned ring_free(input int unsigned cur, input int unsigned bnd,
                                            input int unsigned aw);
    int unsigned span;
    int unsigned d;
    span = 32'd1 << aw;
    d = (bnd - cur) & (span - 32'd1);
    return (d == 32'd0) ? span : d;
  endfunction

endpackage

// File: rtl/rxr_stage.sv
module rxr_stage
  import rxr_pkg::*;
#(
  parameter int AW        = 15,
  parameter int ALIGN_LG2 = 2,
  localparam int CW       = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic          end_good,
  input  logic          end_bad,
  input  logic [AW-1:0] cur_ptr,
  input  logic [CW-1:0] free_bytes,
  output logic          buf_wr_en,
  output logic [AW-1:0] buf_wr_addr,
  output logic          commit_evt,
  output logic          drop_evt,
  output logic          rewind_evt,
  output logic [CW-1:0] commit_len,
  output logic [CW-1:0] staged_cnt,
  output logic          ovf_flag
);
  localparam int ALIGN = 1 << ALIGN_LG2;

  logic [CW-1:0] staged_q;
  logic          ovf_q;
  logic          fits;
  logic          accept;
  logic          ovf_eff;
  logic          end_any;
  logic [CW-1:0] len_fin;

  // room must remain for this byte plus one alignment unit of slack
  assign fits    = (32'(staged_q) + 32'd1 + 32'(ALIGN)) <= 32'(free_bytes);
  assign accept  = byte_vld & ~ovf_q & fits;
  assign ovf_eff = ovf_q | (byte_vld & ~fits);
  assign end_any = end_good | end_bad;
  assign len_fin = staged_q + CW'(accept);

  assign commit_evt = end_good & ~end_bad & ~ovf_eff;
  assign drop_evt   = end_any & ovf_eff;
  assign rewind_evt = end_any & ~commit_evt;
  assign commit_len = CW'(align_up(32'(len_fin), ALIGN_LG2));

  assign buf_wr_en   = accept;
  assign buf_wr_addr = cur_ptr + staged_q[AW-1:0];
  assign staged_cnt  = staged_q;
  assign ovf_flag    = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged_q <= '0;
      ovf_q    <= 1'b0;
    end else if (end_any) begin
      staged_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (accept) staged_q <= staged_q + CW'(1);
      ovf_q <= ovf_eff;
    end
  end

endmodule

// File: rtl/rxr_cur_ptr.sv
module rxr_cur_ptr #(
  parameter int AW  = 15,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_evt,
  input  logic [CW-1:0] commit_len,
  output logic [AW-1:0] cur_ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)          cur_ptr <= '0;
    else if (commit_evt) cur_ptr <= cur_ptr + commit_len[AW-1:0];
  end
endmodule

// File: rtl/rxr_bound.sv
module rxr_bound #(
  parameter int AW        = 15,
  parameter int ALIGN_LG2 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bnd_wr_en,
  input  logic [AW-1:0] bnd_wr_data,
  output logic [AW-1:0] bnd_ptr
);
  logic [AW-ALIGN_LG2-1:0] bnd_hi;

  always_ff @(posedge clk) begin
    if (!rst_n)         bnd_hi <= '0;
    else if (bnd_wr_en) bnd_hi <= bnd_wr_data[AW-1:ALIGN_LG2];
  end

  assign bnd_ptr = {bnd_hi, {ALIGN_LG2{1'b0}}};
endmodule

// File: rtl/rxr_status.sv
module rxr_status
  import rxr_pkg::*;
#(
  parameter int AW        = 15,
  parameter int MAX_FRAME = 1536,
  localparam int CW       = AW + 1
) (
  input  logic [AW-1:0] cur_ptr,
  input  logic [AW-1:0] bnd_ptr,
  output logic [CW-1:0] free_bytes,
  output logic          ring_empty,
  output logic          ring_full
);
  assign free_bytes = CW'(ring_free(32'(cur_ptr), 32'(bnd_ptr), AW));
  assign ring_empty = (cur_ptr == bnd_ptr);
  assign ring_full  = 32'(free_bytes) < 32'(MAX_FRAME);
endmodule

// File: rtl/rx_ring_ptr_mgr.sv
module rx_ring_ptr_mgr #(
  parameter int RING_BYTES = 32768,
  parameter int MAX_FRAME  = 1536,
  parameter int ALIGN_LG2  = 2,
  parameter int DROP_W     = 8,
  localparam int AW        = $clog2(RING_BYTES),
  localparam int CW        = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic              end_good,
  input  logic              end_bad,
  input  logic              bnd_wr_en,
  input  logic [AW-1:0]     bnd_wr_data,
  output logic              buf_wr_en,
  output logic [AW-1:0]     buf_wr_addr,
  output logic [AW-1:0]     cur_ptr,
  output logic [AW-1:0]     bnd_ptr,
  output logic [CW-1:0]     free_bytes,
  output logic              ring_empty,
  output logic              ring_full,
  output logic [DROP_W-1:0] drop_cnt
);
  // internal events, named for the checker
  logic          commit_evt;
  logic          drop_evt;
  logic          rewind_evt;
  logic [CW-1:0] commit_len;
  logic [CW-1:0] staged_cnt;
  logic          ovf_flag;

  rxr_stage #(.AW(AW), .ALIGN_LG2(ALIGN_LG2)) u_stage (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .end_good(end_good), .end_bad(end_bad),
    .cur_ptr(cur_ptr), .free_bytes(free_bytes), .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr),
    .commit_evt(commit_evt), .drop_evt(drop_evt), .rewind_evt(rewind_evt),
    .commit_len(commit_len), .staged_cnt(staged_cnt), .ovf_flag(ovf_flag)
  );

  rxr_cur_ptr #(.AW(AW)) u_cur (
    .clk(clk), .rst_n(rst_n), .commit_evt(commit_evt), .commit_len(commit_len), .cur_ptr(cur_ptr)
  );

  rxr_bound #(.AW(AW), .ALIGN_LG2(ALIGN_LG2)) u_bnd (
    .clk(clk), .rst_n(rst_n), .bnd_wr_en(bnd_wr_en), .bnd_wr_data(bnd_wr_data), .bnd_ptr(bnd_ptr)
  );

  rxr_status #(.AW(AW), .MAX_FRAME(MAX_FRAME)) u_stat (
    .cur_ptr(cur_ptr), .bnd_ptr(bnd_ptr), .free_bytes(free_bytes),
    .ring_empty(ring_empty), .ring_full(ring_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                                drop_cnt <= '0;
    else if (drop_evt && drop_cnt != '1)       drop_cnt <= drop_cnt + DROP_W'(1);
  end

endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int AW        = 15,
  parameter int ALIGN_LG2 = 2,
  parameter int DROP_W    = 8,
  localparam int CW       = AW + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              end_good,
  input logic              end_bad,
  input logic              bnd_wr_en,
  input logic [AW-1:0]     bnd_wr_data,
  input logic              buf_wr_en,
  input logic [AW-1:0]     cur_ptr,
  input logic [AW-1:0]     bnd_ptr,
  input logic [CW-1:0]     free_bytes,
  input logic              ring_empty,
  input logic              ring_full,
  input logic [DROP_W-1:0] drop_cnt,
  input logic              commit_evt,
  input logic              drop_evt,
  input logic              rewind_evt,
  input logic [CW-1:0]     commit_len,
  input logic              ovf_flag
);
  localparam int ALIGN = 1 << ALIGN_LG2;

  a_r3_commit_advance: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> cur_ptr == AW'($past(cur_ptr) + $past(commit_len[AW-1:0])));

  a_r4_rewind_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_evt |=> $stable(cur_ptr));

  a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_evt, drop_evt}));

  a_r5_bound_load: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_wr_en |=> (bnd_ptr[ALIGN_LG2-1:0] == '0) &&
                  (bnd_ptr[AW-1:ALIGN_LG2] == $past(bnd_wr_data[AW-1:ALIGN_LG2])));

  a_r6_empty_free: assert property (@(posedge clk) disable iff (!rst_n)
    ring_empty |-> 32'(free_bytes) == (32'd1 << AW));

  a_r7_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ring_full |-> !ring_empty);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> 32'(commit_len) + 32'(ALIGN) <= 32'(free_bytes));

  a_r8_silent_after_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> !buf_wr_en);

  a_r8_drop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && drop_cnt != '1) |=> drop_cnt == DROP_W'($past(drop_cnt) + DROP_W'(1)));

  a_r8_drop_only_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> (end_good || end_bad));

endmodule

bind rx_ring_ptr_mgr rxr_checker #(.AW(AW), .ALIGN_LG2(ALIGN_LG2), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .end_good(end_good), .end_bad(end_bad),
  .bnd_wr_en(bnd_wr_en), .bnd_wr_data(bnd_wr_data), .buf_wr_en(buf_wr_en),
  .cur_ptr(cur_ptr), .bnd_ptr(bnd_ptr), .free_bytes(free_bytes), .ring_empty(ring_empty),
  .ring_full(ring_full), .drop_cnt(drop_cnt), .commit_evt(commit_evt), .drop_evt(drop_evt),
  .rewind_evt(rewind_evt), .commit_len(commit_len), .ovf_flag(ovf_flag)
);

// File: tb/test_rx_ring_ptr_mgr.sv
module test_rx_ring_ptr_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int RING = 32768;
  localparam int MASK = RING - 1;
  localparam int NVEC = 9;

  // {good, len[15:0], expected write pointer after[14:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {1'b1, 16'd1,    15'd4},
    {1'b1, 16'd7,    15'd12},
    {1'b0, 16'd64,   15'd12},
    {1'b1, 16'd60,   15'd72},
    {1'b1, 16'd1518, 15'd1592},
    {1'b0, 16'd3,    15'd1592},
    {1'b1, 16'd0,    15'd1592},
    {1'b1, 16'd2,    15'd1596},
    {1'b1, 16'd13,   15'd1612}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_vld = 1'b0, end_good = 1'b0, end_bad = 1'b0, bnd_wr_en = 1'b0;
  logic [14:0] bnd_wr_data = '0;
  logic        buf_wr_en, ring_empty, ring_full;
  logic [14:0] buf_wr_addr, cur_ptr, bnd_ptr;
  logic [15:0] free_bytes;
  logic [7:0]  drop_cnt;

  int n_chk = 0, n_fail = 0;
  int m_cur = 0, m_bnd = 0, m_drop = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_ptr_mgr i_rx_ring_ptr_mgr (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .end_good(end_good), .end_bad(end_bad),
    .bnd_wr_en(bnd_wr_en), .bnd_wr_data(bnd_wr_data), .buf_wr_en(buf_wr_en),
    .buf_wr_addr(buf_wr_addr), .cur_ptr(cur_ptr), .bnd_ptr(bnd_ptr), .free_bytes(free_bytes),
    .ring_empty(ring_empty), .ring_full(ring_full), .drop_cnt(drop_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int m_free();
    int d;
    d = (m_bnd - m_cur) & MASK;
    return (d == 0) ? RING : d;
  endfunction

  // drive one packet; compare strobes and addresses against the bench model
  task automatic send_pkt(input int len, input bit good, input bit bad,
                          input bit bw, input int bval, input string req);
    int n = 0, errs = 0, bad_act = 0, bad_exp = 0;
    bit ovf = 0;
    if (len == 0) begin
      @(negedge clk);
      end_good = good; end_bad = bad;
      bnd_wr_en = bw; bnd_wr_data = 15'(bval);
    end
    for (int i = 0; i < len; i++) begin
      bit exp_en;
      bit last;
      @(negedge clk);
      last = (i == len - 1);
      byte_vld = 1'b1;
      end_good = last & good; end_bad = last & bad;   // R10: last byte rides with the marker
      bnd_wr_en = last & bw; bnd_wr_data = 15'(bval);
      #1;
      exp_en = !ovf && (n + 1 + 4 <= m_free());
      if (!exp_en) ovf = 1;
      if (buf_wr_en !== exp_en) begin
        if (errs == 0) begin bad_act = int'(buf_wr_en); bad_exp = int'(exp_en); end
        errs++;
      end else if (exp_en && (int'(buf_wr_addr) != ((m_cur + n) & MASK))) begin
        if (errs == 0) begin bad_act = int'(buf_wr_addr); bad_exp = (m_cur + n) & MASK; end
        errs++;
      end
      if (exp_en) n++;
    end
    @(negedge clk);
    byte_vld = 1'b0; end_good = 1'b0; end_bad = 1'b0; bnd_wr_en = 1'b0;
    if (ovf) m_drop++;
    else if (good && !bad) m_cur = (m_cur + ((n + 3) & ~3)) & MASK;
    if (bw) m_bnd = bval & MASK & ~3;
    #1;
    chk(errs == 0, req, "write strobe/address", bad_act, bad_exp);
  endtask

  task automatic write_bnd(input int val);
    @(negedge clk);
    bnd_wr_en = 1'b1; bnd_wr_data = 15'(val);
    @(negedge clk);
    bnd_wr_en = 1'b0;
    m_bnd = val & MASK & ~3;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(cur_ptr == 0, "R1", "cur_ptr", cur_ptr, 0);
    chk(bnd_ptr == 0, "R1", "bnd_ptr", bnd_ptr, 0);
    chk(ring_empty && !ring_full, "R1", "empty/full", {ring_empty, ring_full}, 2);
    chk(free_bytes == 16'(RING), "R1", "free_bytes", free_bytes, RING);
    chk(drop_cnt == 0, "R1", "drop_cnt", drop_cnt, 0);

    // table walk: R2 R3 R4 R10
    for (int k = 0; k < NVEC; k++) begin
      send_pkt(int'(VEC[k][30:15]), VEC[k][31], !VEC[k][31], 0, 0, "R2");
      chk(int'(cur_ptr) == int'(VEC[k][14:0]), VEC[k][31] ? "R3" : "R4", "cur_ptr after packet",
          cur_ptr, int'(VEC[k][14:0]));
    end
    chk(!ring_empty && free_bytes == 16'(RING - 1612), "R6", "free after table", free_bytes, RING - 1612);

    // R5: low bits of boundary cleared
    write_bnd(15'h0103);
    chk(bnd_ptr == 15'h0100, "R5", "bnd_ptr aligned", bnd_ptr, 'h100);
    chk(int'(free_bytes) == m_free(), "R6", "free across wrap of difference", free_bytes, m_free());

    // R6: equal pointers mean empty
    write_bnd(1612);
    chk(ring_empty && free_bytes == 16'(RING), "R6", "empty when equal", free_bytes, RING);

    // R2/R3: drive pointer across the top of the ring, consuming after each packet
    for (int p = 0; p < 21; p++) begin
      send_pkt(1536, 1, 0, 0, 0, "R2");
      write_bnd(m_cur);
    end
    chk(cur_ptr == 15'd1100, "R3", "cur_ptr after wrap", cur_ptr, 1100);

    // R8: overrun dropped, pointer held
    write_bnd(1100 + 64);
    send_pkt(100, 1, 0, 0, 0, "R8");
    chk(cur_ptr == 15'd1100, "R8", "cur_ptr held on overrun", cur_ptr, 1100);
    chk(drop_cnt == 8'd1, "R8", "drop_cnt", drop_cnt, 1);
    send_pkt(59, 1, 0, 0, 0, "R8");
    chk(cur_ptr == 15'd1160, "R8", "cur_ptr exact fit", cur_ptr, 1160);
    chk(free_bytes == 16'd4 && !ring_empty, "R6", "free left", free_bytes, 4);
    chk(ring_full, "R7", "full below one frame", ring_full, 1);
    send_pkt(1, 0, 1, 0, 0, "R8");
    chk(drop_cnt == 8'd2 && cur_ptr == 15'd1160, "R8", "overrun with bad end", drop_cnt, 2);

    // R9: boundary write together with good end
    write_bnd(1160);
    chk(!ring_full, "R7", "not full when empty", ring_full, 0);
    send_pkt(8, 1, 0, 1, 1200, "R9");
    chk(cur_ptr == 15'd1168, "R9", "cur_ptr with same-cycle bound write", cur_ptr, 1168);
    chk(bnd_ptr == 15'd1200, "R9", "bnd_ptr with same-cycle packet end", bnd_ptr, 1200);
    chk(free_bytes == 16'd32 && ring_full, "R9", "free after both updates", free_bytes, 32);

    // R4: both markers count as bad; next packet restarts at cur_ptr
    write_bnd(1168);
    send_pkt(4, 1, 1, 0, 0, "R4");
    chk(cur_ptr == 15'd1168, "R4", "both markers rewind", cur_ptr, 1168);
    send_pkt(5, 1, 0, 0, 0, "R4");
    chk(cur_ptr == 15'd1176, "R3", "rounded advance", cur_ptr, 1176);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule